// File: doc/BRIEF.md
# DAC Deferred Load and Clear Controller

This block sits between a per-channel correction engine and the DAC output registers of a multi-channel converter. The engine keeps one corrected code per channel (the x2 values) and reports on `calc_busy_n` whether a recalculation is running. Each time it writes an x2 register it pulses `x2_we` with the channel number. The controller marks that channel as changed. When the asynchronous active-low `load_n` request arrives, it copies only the changed channels into the DAC registers and pulses one update strobe for each copied channel. A load request made while the engine is busy is held back until the engine is idle. When `load_n` is held low, every end of a busy period triggers another load.

The asynchronous active-low `clear_n` input puts every output into the cleared state. While clear is active, the DAC register contents stay as they are and load requests are dropped. After `clear_n` returns high, the outputs stay cleared until a load takes place. That load copies every channel and strobes every channel, so all outputs leave the cleared state in the same cycle.

The control is a five-state machine. The states are:
- **RUN**: normal operation, no load pending.
- **PEND**: a load is pending and waits for the engine.
- **CLR**: clear is active.
- **HOLD**: clear has been released and the outputs are still cleared.
- **HOLDPEND**: the first load after a clear is pending on a busy engine.

The transitions are:
- **go_pend** (RUN→PEND) and **go_holdpend** (HOLD→HOLDPEND): a request arrives while the engine is busy.
- **drain** (PEND→RUN): the engine goes idle and the stored load is performed.
- **release** (CLR→HOLD): clear goes high.
- **wake** (HOLD/HOLDPEND→RUN): the load-all is performed.
- **force** (any state→CLR): clear is low.

Top module: `dac_load_ctrl`

## Requirements
- R1: After reset, `dac_all` is all zero, `dac_upd` is zero, `cleared` is 0, and no channel is marked as changed.
- R2: When `load_n` falls while `calc_busy_n` is high, the load happens at the third rising clock edge after the fall, because of two synchronising flops and one output register. Each copied channel `i` shows a one-cycle pulse on `dac_upd[i]`, and its DAC code `dac_all[i*DW +: DW]` takes the value of `x2_all[i*DW +: DW]`.
- R3: A load copies and strobes only the channels written through `x2_we`/`x2_idx` since the previous load. Every other channel keeps its DAC code and gets no strobe. A load with no changed channel produces no strobe.
- R4: A load requested while `calc_busy_n` is low is stored. No strobe appears while the engine is busy. The load happens at the first rising edge at which `calc_busy_n` is high.
- R5: While the synchronised `load_n` is low, each rising edge of `calc_busy_n` causes one load at the next clock edge.
- R6: A single `load_n` pulse, however long it is held, produces exactly one load, and strobes never appear in two consecutive cycles.
- R7: A load clears the changed mark of each channel. An `x2_we` write that is sampled on the same edge as a load is not copied by that load and marks the channel for the next load.
- R8: When `clear_n` is low, `cleared` goes to 1 at the third rising edge after `clear_n` falls. While `cleared` is 1, `dac_all` does not change, and `x2_we` writes are still recorded.
- R9: Load requests made while the synchronised `clear_n` is low are discarded: there is no strobe then, and none after release.
- R10: After `clear_n` returns high, `cleared` stays 1 until the next load. That load strobes all channels, copies every x2 value, drops `cleared` in the same cycle, and leaves no channel marked as changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calc_busy_n | input | 1 | Low while the correction engine recalculates x2 |
| load_n | input | 1 | Asynchronous active-low load request |
| clear_n | input | 1 | Asynchronous active-low clear |
| x2_we | input | 1 | Strobe: an x2 register was written this cycle |
| x2_idx | input | CHW | Channel number of the x2 write |
| x2_all | input | NCH*DW | All corrected codes; channel i at bits i*DW+DW-1 down to i*DW |
| dac_all | output | NCH*DW | All DAC register codes, same packing as x2_all |
| dac_upd | output | NCH | One-cycle strobe per channel on its DAC register load |
| cleared | output | 1 | High while the outputs are in the cleared state |

## Verification
The hardest situation to reach from the ports is an x2 write that lands exactly on the edge where a load is performed. The stimulus reaches it by counting the two synchroniser edges after `load_n` falls and driving `x2_we` in the half-cycle before the third edge. The other hard case is the level-held load: `load_n` stays low while `calc_busy_n` is toggled, so that busy releases rather than request edges trigger the loads. A load pulse given during clear, with no load following the release, shows that the request was really discarded and not merely delayed.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_PEND,
        ST_CLR,
        ST_HOLD,
        ST_HOLDPEND
    } dlc_state_e;
endpackage

// File: rtl/dlc_sync.sv
module dlc_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dlc_dirty.sv
module dlc_dirty #(
    parameter  int NCH = 40,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [CHW-1:0] idx,
    input  logic           fire,
    output logic [NCH-1:0] dirty
);
    for (genvar i = 0; i < NCH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dirty[i] <= 1'b0;
            else if (wr && idx == CHW'(i))
                dirty[i] <= 1'b1;      // a write on the load edge re-marks
            else if (fire)
                dirty[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dlc_fsm.sv
module dlc_fsm
    import dlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_low,
    input  logic ld_fall,
    input  logic busy_rise,
    input  logic idle,
    input  logic clr_low,
    output logic fire,
    output logic fire_all,
    output logic cleared
);
    dlc_state_e state_q, state_d;
    logic       req;

    assign req = ld_fall | (ld_low & busy_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_low) begin
            state_d = ST_CLR;                                   // force
        end else begin
            unique case (state_q)
                ST_RUN:      if (req && !idle) state_d = ST_PEND;  // go_pend
                ST_PEND:     if (idle) state_d = ST_RUN;           // drain
                ST_CLR, ST_HOLD: begin
                    if (req && idle)  state_d = ST_RUN;            // wake
                    else if (req)     state_d = ST_HOLDPEND;       // go_holdpend
                    else              state_d = ST_HOLD;           // release
                end
                ST_HOLDPEND: if (idle) state_d = ST_RUN;           // wake
                default:     state_d = ST_RUN;
            endcase
        end
    end

    always_comb begin
        fire     = 1'b0;
        fire_all = 1'b0;
        cleared  = 1'b0;
        unique case (state_q)
            ST_RUN:      fire = !clr_low && req && idle;
            ST_PEND:     fire = !clr_low && idle;
            ST_CLR, ST_HOLD: begin
                cleared  = 1'b1;
                fire     = !clr_low && req && idle;
                fire_all = fire;
            end
            ST_HOLDPEND: begin
                cleared  = 1'b1;
                fire     = !clr_low && idle;
                fire_all = fire;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl #(
    parameter  int NCH = 40,
    parameter  int DW  = 14,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calc_busy_n,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              x2_we,
    input  logic [CHW-1:0]    x2_idx,
    input  logic [NCH*DW-1:0] x2_all,
    output logic [NCH*DW-1:0] dac_all,
    output logic [NCH-1:0]    dac_upd,
    output logic              cleared
);
    logic [1:0]     sync_q;
    logic           ld_s, clr_s, ld_prev, busy_prev;
    logic           fire, fire_all;
    logic [NCH-1:0] dirty;
    logic [DW-1:0]  code_q [NCH];

    dlc_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_n, clear_n}),
        .q     (sync_q)
    );
    assign ld_s  = sync_q[1];
    assign clr_s = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_prev   <= 1'b1;
            busy_prev <= 1'b1;
        end else begin
            ld_prev   <= ld_s;
            busy_prev <= calc_busy_n;
        end
    end

    dlc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_low    (!ld_s),
        .ld_fall   (ld_prev & !ld_s),
        .busy_rise (calc_busy_n & !busy_prev),
        .idle      (calc_busy_n),
        .clr_low   (!clr_s),
        .fire      (fire),
        .fire_all  (fire_all),
        .cleared   (cleared)
    );

    dlc_dirty #(.NCH(NCH)) u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (x2_we),
        .idx   (x2_idx),
        .fire  (fire),
        .dirty (dirty)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic take;
        assign take = fire & (fire_all | dirty[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[i]  <= '0;
                dac_upd[i] <= 1'b0;
            end else begin
                dac_upd[i] <= take;
                if (take) code_q[i] <= x2_all[i*DW +: DW];
            end
        end

        assign dac_all[i*DW +: DW] = code_q[i];
    end
endmodule

// File: rtl/dlc_chk.sv
module dlc_chk #(
    parameter int NCH = 40,
    parameter int DW  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              calc_busy_n,
    input logic [NCH*DW-1:0] dac_all,
    input logic [NCH-1:0]    dac_upd,
    input logic              cleared
);
    // R6
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_upd != '0) |=> (dac_upd == '0));

    // R4
    upd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_upd != '0) |-> $past(calc_busy_n));

    // R9
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cleared |-> (dac_upd == '0));

    // R8
    clr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cleared |-> $stable(dac_all));

    // R10
    clr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cleared) |-> (dac_upd == '1));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R3
        code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dac_upd[i] |-> $stable(dac_all[i*DW +: DW]));
    end
endmodule

bind dac_load_ctrl dlc_chk #(.NCH(NCH), .DW(DW)) u_dlc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .calc_busy_n (calc_busy_n),
    .dac_all     (dac_all),
    .dac_upd     (dac_upd),
    .cleared     (cleared)
);

// File: tb/test_dac_load_ctrl.sv
module test_dac_load_ctrl;
    localparam int NCH = 40;
    localparam int DW  = 14;
    localparam int CHW = $clog2(NCH);
    localparam int NV  = 6;
    // each entry: {channel, code}
    localparam logic [CHW+DW-1:0] VEC [NV] = '{
        {6'd0,  14'h1F63}, {6'd39, 14'h3FFF}, {6'd1,  14'h1E8F},
        {6'd20, 14'h209C}, {6'd0,  14'h1F64}, {6'd7,  14'h0001}
    };

    logic clk = 1'b0;
    logic rst_n, calc_busy_n, load_n, clear_n, x2_we;
    logic [CHW-1:0]    x2_idx;
    logic [NCH*DW-1:0] x2_all, dac_all;
    logic [NCH-1:0]    dac_upd;
    logic              cleared;
    logic [DW-1:0]     x2m [NCH];
    logic [DW-1:0]     em  [NCH];
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_comb
        for (int i = 0; i < NCH; i++) x2_all[i*DW +: DW] = x2m[i];

    dac_load_ctrl #(.NCH(NCH), .DW(DW)) i_dac_load_ctrl (
        .clk(clk), .rst_n(rst_n), .calc_busy_n(calc_busy_n), .load_n(load_n),
        .clear_n(clear_n), .x2_we(x2_we), .x2_idx(x2_idx), .x2_all(x2_all),
        .dac_all(dac_all), .dac_upd(dac_upd), .cleared(cleared)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_codes(input string req);
        int bad = 0;
        for (int i = 0; i < NCH; i++)
            if (dac_all[i*DW +: DW] !== em[i]) bad++;
        chk(bad == 0, req, "mismatching DAC codes", 64'(bad), 64'd0);
    endtask

    task automatic wr(input int ch, input logic [DW-1:0] v);
        @(negedge clk);
        x2m[ch] = v; x2_we = 1'b1; x2_idx = CHW'(ch);
        @(negedge clk);
        x2_we = 1'b0;
    endtask

    task automatic model_load(input logic [NCH-1:0] m);
        for (int i = 0; i < NCH; i++) if (m[i]) em[i] = x2m[i];
    endtask

    // load_n pulse; strobe expected at the third edge after the fall
    task automatic ld_pulse(input logic [NCH-1:0] exp_upd, input string req);
        @(negedge clk); load_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dac_upd === exp_upd, req, "update strobes", 64'(dac_upd), 64'(exp_upd));
        model_load(exp_upd);
        chk_codes(req);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic count_upd(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (dac_upd != '0) cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0; calc_busy_n = 1'b1; load_n = 1'b1; clear_n = 1'b1;
        x2_we = 1'b0; x2_idx = '0;
        for (int i = 0; i < NCH; i++) begin x2m[i] = '0; em[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dac_upd == '0, "R1", "strobes", 64'(dac_upd), 64'd0);
        chk(dac_all == '0, "R1", "codes nonzero", 64'(dac_all != '0), 64'd0);
        chk(cleared == 1'b0, "R1", "cleared", 64'(cleared), 64'd0);
        // R3 nothing changed: no strobe
        ld_pulse('0, "R3");

        // R2 table of single-channel loads
        for (int v = 0; v < NV; v++) begin
            wr(int'(VEC[v][CHW+DW-1:DW]), VEC[v][DW-1:0]);
            ld_pulse(NCH'(1) << VEC[v][CHW+DW-1:DW], "R2");
        end

        // R3 two changed channels only
        wr(3, 14'h0333); wr(4, 14'h0444);
        ld_pulse((NCH'(1) << 3) | (NCH'(1) << 4), "R3");

        // R6 one long pulse gives exactly one load
        wr(9, 14'h0999);
        @(negedge clk); load_n = 1'b0;
        count_upd(12, cnt);
        chk(cnt == 1, "R6", "loads during held request", 64'(cnt), 64'd1);
        model_load(NCH'(1) << 9);
        chk_codes("R6");

        // R5 load_n still low: each busy release loads
        @(negedge clk); calc_busy_n = 1'b0;
        wr(10, 14'h0AAA);
        count_upd(3, cnt);
        chk(cnt == 0, "R5", "strobes while busy", 64'(cnt), 64'd0);
        @(negedge clk); calc_busy_n = 1'b1;
        @(negedge clk);
        chk(dac_upd === (NCH'(1) << 10), "R5", "first release", 64'(dac_upd), 64'(NCH'(1) << 10));
        model_load(NCH'(1) << 10);
        @(negedge clk); calc_busy_n = 1'b0;
        wr(11, 14'h0BBB); wr(12, 14'h0CCC);
        @(negedge clk); calc_busy_n = 1'b1;
        @(negedge clk);
        chk(dac_upd === ((NCH'(1) << 11) | (NCH'(1) << 12)), "R5", "second release",
            64'(dac_upd), 64'((NCH'(1) << 11) | (NCH'(1) << 12)));
        model_load((NCH'(1) << 11) | (NCH'(1) << 12));
        chk_codes("R5");
        load_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 request during busy is stored
        calc_busy_n = 1'b0;
        wr(13, 14'h0DDD);
        @(negedge clk); load_n = 1'b0;
        count_upd(3, cnt);
        load_n = 1'b1;
        begin
            int c2;
            count_upd(6, c2);
            cnt += c2;
        end
        chk(cnt == 0, "R4", "strobes while busy", 64'(cnt), 64'd0);
        calc_busy_n = 1'b1;
        @(negedge clk);
        chk(dac_upd === (NCH'(1) << 13), "R4", "stored load", 64'(dac_upd), 64'(NCH'(1) << 13));
        model_load(NCH'(1) << 13);
        chk_codes("R4");
        repeat (3) @(negedge clk);

        // R7 write on the load edge waits for the next load
        wr(14, 14'h0EEE);
        @(negedge clk); load_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        x2m[15] = 14'h0ABC; x2_we = 1'b1; x2_idx = CHW'(15);
        @(posedge clk);
        @(negedge clk);
        x2_we = 1'b0;
        chk(dac_upd === (NCH'(1) << 14), "R7", "coincident write", 64'(dac_upd), 64'(NCH'(1) << 14));
        model_load(NCH'(1) << 14);
        chk_codes("R7");
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        ld_pulse(NCH'(1) << 15, "R7");

        // R8 clear entry
        @(negedge clk); clear_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cleared == 1'b0, "R8", "cleared too early", 64'(cleared), 64'd0);
        @(posedge clk); @(negedge clk);
        chk(cleared == 1'b1, "R8", "cleared", 64'(cleared), 64'd1);
        // R9 request during clear is discarded
        wr(16, 14'h1616);
        @(negedge clk); load_n = 1'b0;
        count_upd(4, cnt);
        load_n = 1'b1;
        begin
            int c2;
            count_upd(4, c2);
            cnt += c2;
        end
        chk(cnt == 0, "R9", "strobes during clear", 64'(cnt), 64'd0);
        chk_codes("R8");
        @(negedge clk); clear_n = 1'b1;
        count_upd(8, cnt);
        chk(cnt == 0, "R9", "strobes after release", 64'(cnt), 64'd0);
        // R10 still cleared until a load
        chk(cleared == 1'b1, "R10", "cleared after release", 64'(cleared), 64'd1);
        ld_pulse('1, "R10");
        chk(cleared == 1'b0, "R10", "cleared after load", 64'(cleared), 64'd0);
        ld_pulse('0, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule